// File: doc/BRIEF.md
# Floppy Head Recalibration Sequencer

This block returns a floppy drive head to track zero after power-up and reports the outcome as a self-test result byte. A single start pulse begins a run. If the drive-present input is low, no step is issued: the block marks "no drive" in the result and finishes at once.

When a drive is attached, the block checks the track-zero sense before every step. It issues outward step requests one at a time. Each request is held until the drive logic acknowledges it with a step-done pulse. After each acknowledgement the block waits a programmable number of settle cycles before it samples track zero again. Stepping stops as soon as track zero is seen, and the number of steps used stays visible on a count output.

If track zero has still not appeared after the step budget is used up (80 by default), the result byte carries a fault flag. A one-cycle done strobe marks the moment the result byte becomes valid. The byte then holds until the next start, so a host processor can read it later.

Top module: `trk0_recal_seq`

## Requirements
- R1: After reset, `step_req_o` and `done_o` are low, `result_o` is 0 and `steps_o` is 0.
- R2: Step requests are issued one at a time. `step_req_o` stays high until a cycle in which `step_done_i` is high, drops in the following cycle, and each request raises `steps_o` by one.
- R3: With `settle_i` = N, once a step is acknowledged and track zero is still low, the next `step_req_o` rises exactly N+2 clock cycles after the edge that accepted `step_done_i`.
- R4: When track zero is sampled high, no further request is issued. The run ends with `result_o` = 0x00 and `steps_o` equal to the number of requests issued. A head already at track zero ends with 0 steps.
- R5: At most MAX_SEEKS (80) requests are issued. If track zero is still low after the last settle, the result has bit 1 set (fault, value 0x02) and `steps_o` = 80. Track zero reached on exactly the 80th step counts as success.
- R6: A start while `drive_present_i` is low issues no step request. `done_o` goes high in the cycle after the start, with `result_o` = 0x01 (bit 0, no drive), the fault bit clear and `steps_o` = 0.
- R7: `done_o` is high for exactly one cycle per run. `result_o` and `steps_o` are valid while it is high and hold their values until the next start.
- R8: A start with a drive present clears `result_o` and `steps_o` to 0 in the cycle after the start.
- R9: A start pulse that arrives while a run is in progress is ignored. The run continues and ends with the same result and step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| drive_present_i | input | 1 | High when a drive is attached |
| trk0_i | input | 1 | Track-zero sense from the drive |
| step_done_i | input | 1 | Acknowledge of the current step request |
| settle_i | input | SETTLE_W | Settle cycles to wait after each step |
| step_req_o | output | 1 | Outward step request, held until acknowledged |
| done_o | output | 1 | One-cycle strobe when the result is valid |
| result_o | output | RESULT_W | Result byte: bit 0 no drive, bit 1 fault |
| steps_o | output | STEP_W | Number of steps used in the last run |

## Verification
The bench builds the block with SYNC_STAGES = 0 and keeps the default MAX_SEEKS of 80. With no synchronizer, the track-zero sample is cycle-exact, so the N+2 request spacing can be checked even at a settle count of 0, and a head change at the acknowledge is seen at the very next check. Keeping the real budget of 80 puts both sides of the limit within reach: success on exactly the 80th step, and a fault for a head that needs more. A behavioural drive model moves the head on each acknowledge. It can delay its acknowledge, which tests that the request is held.

// File: rtl/trk0_pkg.sv
package trk0_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_STEP,
      ST_SETTLE,
      ST_FINISH
   } seq_state_t;

   // Result byte bit positions
   localparam int RES_NODRIVE_BIT = 0;
   localparam int RES_FAULT_BIT   = 1;

endpackage

// File: rtl/trk0_sync.sv
module trk0_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("trk0_sync: STAGES must be non-negative");
      end

      if (STAGES == 0) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/trk0_step_counter.sv
module trk0_step_counter #(
   parameter int MAX_SEEKS = 80,
   parameter int STEP_W    = $clog2(MAX_SEEKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   output logic [STEP_W-1:0] count_o,
   output logic              at_max_o
);

   localparam logic [STEP_W-1:0] LIMIT = STEP_W'(MAX_SEEKS);

   logic [STEP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr_i)                  cnt_q <= '0;
      else if (inc_i && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o  = cnt_q;
   assign at_max_o = (cnt_q == LIMIT);

   AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT); // R5

   AST_STEP_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && !at_max_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/trk0_settle_timer.sv
module trk0_settle_timer #(
   parameter int SETTLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [SETTLE_W-1:0] value_i,
   input  logic                dec_i,
   output logic                zero_o
);

   logic [SETTLE_W-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     tmr_q <= '0;
      else if (load_i)                tmr_q <= value_i;
      else if (dec_i && tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
   end

   assign zero_o = (tmr_q == '0);

   AST_SETTLE_DECR: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i && !zero_o) |=> (tmr_q == $past(tmr_q) - 1'b1)); // R3

endmodule

// File: rtl/trk0_result_reg.sv
module trk0_result_reg
   import trk0_pkg::*;
#(
   parameter int RESULT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                load_i,
   input  logic                nodrive_i,
   input  logic                fault_i,
   output logic [RESULT_W-1:0] result_o
);

   logic [RESULT_W-1:0] code;
   logic [RESULT_W-1:0] res_q;

   always_comb begin
      code = '0;
      code[RES_NODRIVE_BIT] = nodrive_i;
      code[RES_FAULT_BIT]   = fault_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q <= '0;
      else if (load_i) res_q <= code;
      else if (clr_i)  res_q <= '0;
   end

   assign result_o = res_q;

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !clr_i) |=> $stable(res_q)); // R7

endmodule

// File: rtl/trk0_recal_seq.sv
module trk0_recal_seq
   import trk0_pkg::*;
#(
   parameter int MAX_SEEKS   = 80,
   parameter int SETTLE_W    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RESULT_W    = 8,
   parameter int STEP_W      = $clog2(MAX_SEEKS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                drive_present_i,
   input  logic                trk0_i,
   input  logic                step_done_i,
   input  logic [SETTLE_W-1:0] settle_i,
   output logic                step_req_o,
   output logic                done_o,
   output logic [RESULT_W-1:0] result_o,
   output logic [STEP_W-1:0]   steps_o
);

   generate
      if (MAX_SEEKS < 1) begin : g_bad_max
         $error("trk0_recal_seq: MAX_SEEKS must be at least 1");
      end
      if ((1 << STEP_W) <= MAX_SEEKS) begin : g_bad_stepw
         $error("trk0_recal_seq: STEP_W too narrow for MAX_SEEKS");
      end
      if (RESULT_W < 2) begin : g_bad_resw
         $error("trk0_recal_seq: RESULT_W must hold both flag bits");
      end
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("trk0_recal_seq: SETTLE_W must be at least 1");
      end
   endgenerate

   seq_state_t state_q, state_d;

   logic trk0_s;
   logic cnt_clr, cnt_inc, cnt_at_max;
   logic tmr_load, tmr_dec, tmr_zero;
   logic res_clr, res_load, code_nodrive, code_fault;

   trk0_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (trk0_i),
      .q_o   (trk0_s)
   );

   trk0_step_counter #(.MAX_SEEKS(MAX_SEEKS), .STEP_W(STEP_W)) u_steps (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (cnt_clr),
      .inc_i    (cnt_inc),
      .count_o  (steps_o),
      .at_max_o (cnt_at_max)
   );

   trk0_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tmr_load),
      .value_i (settle_i),
      .dec_i   (tmr_dec),
      .zero_o  (tmr_zero)
   );

   trk0_result_reg #(.RESULT_W(RESULT_W)) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (res_clr),
      .load_i    (res_load),
      .nodrive_i (code_nodrive),
      .fault_i   (code_fault),
      .result_o  (result_o)
   );

   always_comb begin
      state_d      = state_q;
      cnt_clr      = 1'b0;
      cnt_inc      = 1'b0;
      tmr_load     = 1'b0;
      tmr_dec      = 1'b0;
      res_clr      = 1'b0;
      res_load     = 1'b0;
      code_nodrive = 1'b0;
      code_fault   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               res_clr = 1'b1;
               cnt_clr = 1'b1;
               if (!drive_present_i) begin
                  res_load     = 1'b1;
                  code_nodrive = 1'b1;
                  state_d      = ST_FINISH;
               end else begin
                  state_d = ST_CHECK;
               end
            end
         end
         ST_CHECK: begin
            if (trk0_s) begin
               res_load = 1'b1;
               state_d  = ST_FINISH;
            end else if (cnt_at_max) begin
               res_load   = 1'b1;
               code_fault = 1'b1;
               state_d    = ST_FINISH;
            end else begin
               cnt_inc = 1'b1;
               state_d = ST_STEP;
            end
         end
         ST_STEP: begin
            if (step_done_i) begin
               tmr_load = 1'b1;
               state_d  = ST_SETTLE;
            end
         end
         ST_SETTLE: begin
            if (tmr_zero) state_d = ST_CHECK;
            else          tmr_dec = 1'b1;
         end
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign step_req_o = (state_q == ST_STEP);
   assign done_o     = (state_q == ST_FINISH);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req_o && !step_done_i) |=> step_req_o); // R2

   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req_o && step_done_i) |=> !step_req_o); // R2

   AST_FAULT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o[RES_FAULT_BIT]) |-> (steps_o == STEP_W'(MAX_SEEKS))); // R5

   AST_NODRIVE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o[RES_NODRIVE_BIT]) |-> (!result_o[RES_FAULT_BIT] && steps_o == '0)); // R6

   AST_NODRIVE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i && !drive_present_i) |=> done_o); // R6

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STEP && start_i && !step_done_i) |=> (state_q == ST_STEP)); // R9

endmodule

// File: tb/trk0_recal_seq_test.sv
module trk0_recal_seq_test;

   localparam int MAXS   = 80;
   localparam int SW     = 16;
   localparam int RW     = 8;
   localparam int STW    = $clog2(MAXS + 1);
   localparam int LOOP_LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic drive_present_i = 1'b0;
   logic trk0_i = 1'b0;
   logic step_done_i = 1'b0;
   logic [SW-1:0] settle_i = '0;
   logic step_req_o, done_o;
   logic [RW-1:0] result_o;
   logic [STW-1:0] steps_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Run outcome
   int run_reqs;
   int run_done_cyc;
   logic [RW-1:0] run_result;
   int run_steps;
   bit run_timeout;

   always #2.5 clk = ~clk;   // 200 MHz

   trk0_recal_seq #(
      .MAX_SEEKS(MAXS), .SETTLE_W(SW), .SYNC_STAGES(0), .RESULT_W(RW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .drive_present_i(drive_present_i), .trk0_i(trk0_i),
      .step_done_i(step_done_i), .settle_i(settle_i),
      .step_req_o(step_req_o), .done_o(done_o),
      .result_o(result_o), .steps_o(steps_o)
   );

   task automatic check(input string req, input int actual, input int expected, input string what);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
      end
   endtask

   // Runs one sequence with a behavioural drive. Called at a negedge.
   task automatic run_seq(input bit present, input int pos0, input int settle,
                          input int ack_delay, input bit inject, input bit check_clear);
      int pos = pos0;
      int gap = 0;
      int held = 0;
      bit acked = 0;
      bit injected = 0;
      int cyc = 0;
      run_reqs = 0; run_timeout = 0; run_done_cyc = -1;
      drive_present_i = present;
      settle_i = SW'(settle);
      trk0_i = (pos == 0);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1;
      if (check_clear) begin
         check("R8", int'(result_o), 0, "result cleared after start");
         check("R8", int'(steps_o), 0, "steps cleared after start");
      end
      forever begin
         start_i = 1'b0;
         if (done_o) begin
            run_done_cyc = cyc;
            run_result = result_o;
            run_steps = int'(steps_o);
            break;
         end
         if (step_req_o) begin
            if (held == 0 && run_reqs > 0)
               check("R3", gap, settle + 2, "cycles from acknowledge to next request");
            held++;
            if (!acked && held > ack_delay) begin
               step_done_i = 1'b1;
               acked = 1;
               run_reqs++;
               gap = 0;
               if (pos > 0) pos--;
               trk0_i = (pos == 0);
            end
         end else begin
            if (held > 0 && !acked) begin
               errors++; checks++;
               $display("FAIL R2 request dropped without acknowledge: actual 0 expected 1");
            end
            step_done_i = 1'b0;
            acked = 0;
            held = 0;
            gap++;
            if (inject && !injected && run_reqs == 2) begin
               start_i = 1'b1;
               injected = 1;
            end
         end
         @(negedge clk);
         cyc++;
         if (cyc > LOOP_LIMIT) begin
            run_timeout = 1;
            break;
         end
      end
      step_done_i = 1'b0;
      start_i = 1'b0;
      check("R7", int'(run_timeout), 0, "run timeout");
      if (!run_timeout) begin
         @(negedge clk);
         check("R7", int'(done_o), 0, "done lasts one cycle");
         repeat (4) @(negedge clk);
         check("R7", int'(result_o), int'(run_result), "result held after done");
         check("R7", run_steps, int'(steps_o), "steps held after done");
      end
   endtask

   task automatic t_reset;
      check("R1", int'(step_req_o), 0, "step_req after reset");
      check("R1", int'(done_o), 0, "done after reset");
      check("R1", int'(result_o), 0, "result after reset");
      check("R1", int'(steps_o), 0, "steps after reset");
   endtask

   task automatic t_no_drive;
      run_seq(1'b0, 5, 3, 0, 1'b0, 1'b0);
      check("R6", run_reqs, 0, "no drive: requests");
      check("R6", run_done_cyc, 1, "no drive: cycles to done");
      check("R6", int'(run_result), 8'h01, "no drive: result");
      check("R6", run_steps, 0, "no drive: steps");
   endtask

   task automatic t_short_seek;
      run_seq(1'b1, 3, 4, 0, 1'b0, 1'b1);
      check("R4", int'(run_result), 8'h00, "short seek: result");
      check("R4", run_steps, 3, "short seek: steps");
      check("R2", run_reqs, 3, "short seek: requests");
   endtask

   task automatic t_at_zero;
      run_seq(1'b1, 0, 2, 0, 1'b0, 1'b1);
      check("R4", int'(run_result), 8'h00, "already at zero: result");
      check("R4", run_steps, 0, "already at zero: steps");
      check("R4", run_reqs, 0, "already at zero: requests");
   endtask

   task automatic t_slow_ack_zero_settle;
      run_seq(1'b1, 5, 0, 3, 1'b0, 1'b1);
      check("R2", run_reqs, 5, "slow acknowledge: requests");
      check("R2", run_steps, 5, "slow acknowledge: steps");
      check("R4", int'(run_result), 8'h00, "slow acknowledge: result");
   endtask

   task automatic t_limit_success;
      run_seq(1'b1, MAXS, 1, 0, 1'b0, 1'b1);
      check("R5", int'(run_result), 8'h00, "zero on last step: result");
      check("R5", run_steps, MAXS, "zero on last step: steps");
   endtask

   task automatic t_limit_fault;
      run_seq(1'b1, MAXS + 40, 1, 0, 1'b0, 1'b1);
      check("R5", int'(run_result), 8'h02, "never zero: result");
      check("R5", run_steps, MAXS, "never zero: steps");
      check("R5", run_reqs, MAXS, "never zero: requests");
   endtask

   task automatic t_clear_after_fault;
      run_seq(1'b1, 2, 2, 0, 1'b0, 1'b1);
      check("R8", int'(run_result), 8'h00, "rerun after fault: result");
      check("R8", run_steps, 2, "rerun after fault: steps");
   endtask

   task automatic t_start_mid_run;
      run_seq(1'b1, 6, 3, 0, 1'b1, 1'b1);
      check("R9", int'(run_result), 8'h00, "start mid-run: result");
      check("R9", run_steps, 6, "start mid-run: steps");
      check("R9", run_reqs, 6, "start mid-run: requests");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_drive();
      t_short_seek();
      t_at_zero();
      t_slow_ack_zero_settle();
      t_limit_success();
      t_limit_fault();
      t_clear_after_fault();
      t_start_mid_run();
      t_no_drive();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule